// File: doc/BRIEF.md
# Column-Counter Unsigned Multiplier

This block is a purely combinational unsigned multiplier. With its default widths it takes two 24-bit operands and returns their full 48-bit product, with no truncation and no rounding. It first forms every single-bit AND of one bit of each operand. It then works through the result columns from least to most significant. Each column is collapsed by one ones-counter, and the counter is sized to the number of bits that land in that column.

The rule for carries is simple. The lowest bit of a column's count becomes the product bit for that column. Every higher bit k of the count is fed into the column k places further up as one more input. Because of this, a column's counter width depends on its own partial products and on the carries arriving from below. Those widths are worked out at elaboration. The lowest column needs no counter. The next one is a half adder. The middle columns need the widest counters, and the counters narrow again toward the top of the product.

Both operand widths are parameters, so the same source serves a 24x24 datapath and a 4x4 instance small enough to check over every input pair. The block has no clock and no state. The product settles from the operands within the same cycle.

Top module: `cmul_column_mult`

## Requirements
- R1: `product` equals the unsigned product `op_a * op_b` over its full `OPA_W+OPB_W` bits, for any operand values.
- R2: `product[0]` equals `op_a[0] & op_b[0]`, since the lowest column holds a single partial product and receives no carry.
- R3: No count bit is ever carried beyond the most significant product column: every count bit that would land above bit `OPA_W+OPB_W-1` is zero. With all-ones operands the top product bit is 1.
- R4: Every column counter outputs the exact number of ones among its inputs (partial products plus arriving carries). This holds even when all inputs of the widest column are 1, which happens with all-ones operands.
- R5: If either operand is zero, `product` is zero.
- R6: If one operand is the single power of two 2^k, `product` equals the other operand shifted left by k places. In particular, `op_b == 1` gives `product == op_a`.
- R7: All-ones operands give (2^OPA_W-1)*(2^OPB_W-1), which is 0xFFFFFE000001 at the default widths.
- R8: A 4x4 instance gives the exact product for all 256 operand pairs.
- R9: `product[1]` equals `(op_a[1]&op_b[0]) ^ (op_a[0]&op_b[1])`. Column 1 is reduced by a half adder, and its carry goes to column 2.
- R10: The block has no register. `product` follows an operand change before any further clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | OPA_W (24) | Unsigned multiplicand |
| op_b | input | OPB_W (24) | Unsigned multiplier |
| product | output | OPA_W+OPB_W (48) | Full unsigned product |

## Verification
The hardest case to reach is a long ripple of count bits through the middle columns, where the widest counters sit. It needs almost every input of those counters to be 1 at the same time. Random operands seldom get there. The all-ones pair, powers of two against dense values, and the full 4x4 sweep are driven on purpose to fill whole columns and to push carries right up to the top product bit. Random 24-bit pairs then cover the mixed patterns between those extremes.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

   // Bound on columns handled by the elaboration-time helpers.
   localparam int MAX_COLS = 256;

   // Number of AND partial products whose weight equals col.
   function automatic int pp_in_col(input int col, input int aw, input int bw);
      int n;
      n = 0;
      for (int a = 0; a < aw; a++)
         if ((col - a) >= 0 && (col - a) < bw) n++;
      return n;
   endfunction

   // Index of operand A bit of the first partial product in column col.
   function automatic int pp_first(input int col, input int bw);
      return (col - bw + 1 > 0) ? (col - bw + 1) : 0;
   endfunction

   // Width of a count able to hold the value n.
   function automatic int cnt_width(input int n);
      return (n <= 1) ? 1 : $clog2(n + 1);
   endfunction

   // Total inputs of column col: partial products plus arriving count bits.
   function automatic int col_inputs(input int col, input int aw, input int bw);
      int n [MAX_COLS];
      for (int c = 0; c <= col; c++) begin
         n[c] = pp_in_col(c, aw, bw);
         for (int j = 0; j < c; j++)
            if ((c - j) < cnt_width(n[j])) n[c]++;
      end
      return n[col];
   endfunction

   // Input position in column col taken by the carry bit from column src.
   function automatic int carry_slot(input int col, input int src,
                                     input int aw, input int bw);
      int n [MAX_COLS];
      int s;
      for (int c = 0; c <= col; c++) begin
         n[c] = pp_in_col(c, aw, bw);
         for (int j = 0; j < c; j++)
            if ((c - j) < cnt_width(n[j])) n[c]++;
      end
      s = pp_in_col(col, aw, bw);
      for (int j = 0; j < src; j++)
         if ((col - j) < cnt_width(n[j])) s++;
      return s;
   endfunction

endpackage

// File: rtl/cmul_pp_gen.sv
module cmul_pp_gen #(
   parameter int OPA_W = 24,
   parameter int OPB_W = 24
) (
   input  logic [OPA_W-1:0]            op_a,
   input  logic [OPB_W-1:0]            op_b,
   output logic [OPA_W-1:0][OPB_W-1:0] pp
);

   if (OPA_W < 1 || OPB_W < 1) begin : g_bad_width
      $error("cmul_pp_gen: operand widths must be positive");
   end

   for (genvar a = 0; a < OPA_W; a++) begin : g_row
      for (genvar b = 0; b < OPB_W; b++) begin : g_bit
         assign pp[a][b] = op_a[a] & op_b[b];
      end
   end

endmodule

// File: rtl/cmul_ones_counter.sv
module cmul_ones_counter #(
   parameter int N_IN  = 4,
   parameter int CNT_W = 3
) (
   input  logic [N_IN-1:0]  bits,
   output logic [CNT_W-1:0] count
);

   localparam int NEED_W = (N_IN <= 1) ? 1 : $clog2(N_IN + 1);

   if (N_IN < 1) begin : g_bad_n
      $error("cmul_ones_counter: needs at least one input");
   end
   if (CNT_W < NEED_W) begin : g_bad_w
      $error("cmul_ones_counter: count width too small for input count");
   end

   if (N_IN == 1) begin : g_wire
      assign count = CNT_W'(bits);
   end else if (N_IN == 2) begin : g_half
      logic [1:0] hsum;
      assign hsum  = {bits[0] & bits[1], bits[0] ^ bits[1]};
      assign count = CNT_W'(hsum);
   end else if (N_IN == 3) begin : g_full
      logic [1:0] fsum;
      assign fsum  = {(bits[0] & bits[1]) | (bits[2] & (bits[0] ^ bits[1])),
                      bits[0] ^ bits[1] ^ bits[2]};
      assign count = CNT_W'(fsum);
   end else begin : g_split
      localparam int LO_N = N_IN / 2;
      localparam int HI_N = N_IN - LO_N;
      localparam int LO_W = $clog2(LO_N + 1);
      localparam int HI_W = $clog2(HI_N + 1);
      logic [LO_W-1:0] lo_cnt;
      logic [HI_W-1:0] hi_cnt;

      cmul_ones_counter #(.N_IN(LO_N), .CNT_W(LO_W)) u_lo (
         .bits  (bits[LO_N-1:0]),
         .count (lo_cnt)
      );
      cmul_ones_counter #(.N_IN(HI_N), .CNT_W(HI_W)) u_hi (
         .bits  (bits[N_IN-1:LO_N]),
         .count (hi_cnt)
      );

      assign count = CNT_W'(lo_cnt) + CNT_W'(hi_cnt);
   end

   // R4: the count is exactly the number of set inputs.
   always_comb begin
      assert_exact_count_R4: assert (int'(count) == $countones(bits))
         else $error("R4: counter output %0d, ones %0d", count, $countones(bits));
   end

endmodule

// File: rtl/cmul_column_mult.sv
module cmul_column_mult #(
   parameter int OPA_W = 24,
   parameter int OPB_W = 24
) (
   input  logic [OPA_W-1:0]       op_a,
   input  logic [OPB_W-1:0]       op_b,
   output logic [OPA_W+OPB_W-1:0] product
);

   localparam int COLS = OPA_W + OPB_W;

   if (OPA_W < 2 || OPB_W < 2) begin : g_bad_width
      $error("cmul_column_mult: each operand needs at least two bits");
   end
   if (COLS > cmul_pkg::MAX_COLS) begin : g_bad_cols
      $error("cmul_column_mult: product wider than helper bound");
   end

   logic [OPA_W-1:0][OPB_W-1:0] pp;

   cmul_pp_gen #(.OPA_W(OPA_W), .OPB_W(OPB_W)) u_pp (
      .op_a (op_a),
      .op_b (op_b),
      .pp   (pp)
   );

   for (genvar i = 0; i < COLS; i++) begin : g_col
      localparam int NPP = cmul_pkg::pp_in_col(i, OPA_W, OPB_W);
      localparam int NIN = cmul_pkg::col_inputs(i, OPA_W, OPB_W);
      localparam int CW  = cmul_pkg::cnt_width(NIN);
      localparam int A0  = cmul_pkg::pp_first(i, OPB_W);

      logic [CW-1:0] cnt;

      if (NIN == 0) begin : g_empty
         assign cnt = '0;
      end else begin : g_busy
         logic [NIN-1:0] col_bits;

         for (genvar p = 0; p < NPP; p++) begin : g_pp
            assign col_bits[p] = pp[A0+p][i-A0-p];
         end

         for (genvar j = 0; j < i; j++) begin : g_cin
            if ((i - j) < cmul_pkg::cnt_width(cmul_pkg::col_inputs(j, OPA_W, OPB_W)))
            begin : g_take
               assign col_bits[cmul_pkg::carry_slot(i, j, OPA_W, OPB_W)] = g_col[j].cnt[i-j];
            end
         end

         cmul_ones_counter #(.N_IN(NIN), .CNT_W(CW)) u_cnt (
            .bits  (col_bits),
            .count (cnt)
         );
      end

      assign product[i] = cnt[0];

      // R3: count bits aimed past the top column must stay clear.
      for (genvar k = 1; k < CW; k++) begin : g_edge
         if (i + k >= COLS) begin : g_drop
            always_comb begin
               assert_no_overflow_R3: assert (cnt[k] == 1'b0)
                  else $error("R3: carry lost above column %0d", COLS - 1);
            end
         end
      end
   end

   always_comb begin
      assert_lsb_R2: assert (product[0] == (op_a[0] & op_b[0]))
         else $error("R2: lowest product bit wrong");
      assert_half_col_R9: assert (product[1] == ((op_a[1] & op_b[0]) ^ (op_a[0] & op_b[1])))
         else $error("R9: column 1 sum wrong");
      if (op_a == '0 || op_b == '0) begin
         assert_zero_R5: assert (product == '0)
            else $error("R5: zero operand gave %h", product);
      end
      if (op_b == OPB_W'(1)) begin
         assert_unit_R6: assert (product == COLS'(op_a))
            else $error("R6: unit multiplier gave %h", product);
      end
   end

endmodule

// File: tb/cmul_column_mult_tb.sv
module cmul_column_mult_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] a24 = '0, b24 = '0;
   logic [3:0]  a4 = '0, b4 = '0;
   logic [47:0] p24;
   logic [7:0]  p4;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   cmul_column_mult #(.OPA_W(24), .OPB_W(24)) u_dut (
      .op_a (a24), .op_b (b24), .product (p24)
   );

   cmul_column_mult #(.OPA_W(4), .OPB_W(4)) u_dut_small (
      .op_a (a4), .op_b (b4), .product (p4)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      end
   endtask

   // Behavioural reference: full-width integer product.
   function automatic logic [47:0] ref24(input logic [23:0] x, input logic [23:0] y);
      longint unsigned r;
      r = longint'(x) * longint'(y);
      return r[47:0];
   endfunction

   // Drive after a rising edge, compare at the following falling edge.
   task automatic apply24(input logic [23:0] x, input logic [23:0] y, input string tag);
      logic [47:0] e;
      @(posedge clk); #2;
      a24 = x; b24 = y;
      @(negedge clk);
      e = ref24(x, y);
      check(tag, 64'(p24), 64'(e));
      check("R2 lsb", 64'(p24[0]), 64'(x[0] & y[0]));
      check("R9 column1", 64'(p24[1]), 64'((x[1] & y[0]) ^ (x[0] & y[1])));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      // Reset phase: operands held at zero.
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R5 reset zero 24", 64'(p24), 64'd0);
      check("R5 reset zero 4", 64'(p4), 64'd0);
      rst_n = 1'b1;

      // R8: exhaustive 4x4 sweep.
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            @(posedge clk); #2;
            a4 = 4'(x); b4 = 4'(y);
            @(negedge clk);
            check("R8 4x4", 64'(p4), 64'(x * y));
         end
      end

      // Zero operands.
      apply24(24'h0, 24'hABCDEF, "R5 a zero");
      apply24(24'h123456, 24'h0, "R5 b zero");
      apply24(24'h0, 24'h0, "R5 both zero");

      // All ones: widest columns fully set, carries reach the top bit.
      apply24(24'hFFFFFF, 24'hFFFFFF, "R7 all ones");
      check("R7 all ones value", 64'(p24), 64'h0000_FFFF_FE00_0001);
      check("R3 top bit", 64'(p24[47]), 64'd1);
      check("R4 full column count", 64'(p24), 64'(ref24(24'hFFFFFF, 24'hFFFFFF)));
      apply24(24'hFFFFFF, 24'h000001, "R6 unit b");
      apply24(24'h000001, 24'hFFFFFF, "R6 unit a");

      // Powers of two against dense and random values.
      for (int k = 0; k < 24; k++) begin
         logic [23:0] v;
         v = 24'($urandom());
         apply24(24'(1) << k, v, "R6 power a");
         check("R6 shift a", 64'(p24), 64'(48'(v) << k));
         apply24(24'hFFFFFF, 24'(1) << k, "R6 power b");
         check("R6 shift b", 64'(p24), 64'(48'hFFFFFF << k));
      end

      // Alternating patterns.
      apply24(24'hAAAAAA, 24'h555555, "R1 alternating");
      apply24(24'hAAAAAA, 24'hAAAAAA, "R1 alternating same");
      apply24(24'h800000, 24'h800000, "R3 top powers");

      // Random operands.
      for (int n = 0; n < 1000; n++) begin
         apply24(24'($urandom()), 24'($urandom()), "R1 random");
      end

      // R10: output follows operands with no clock edge in between.
      @(posedge clk); #2;
      a24 = 24'h00F00F; b24 = 24'h0F0F00;
      #3;
      check("R10 no clock", 64'(p24), 64'(ref24(24'h00F00F, 24'h0F0F00)));
      a24 = 24'h000321; b24 = 24'h000123;
      #3;
      check("R10 follows change", 64'(p24), 64'(ref24(24'h000321, 24'h000123)));

      summary();
      $finish;
   end

endmodule